// File: doc/BRIEF.md
# Per-Channel Output Power Mode Controller

This block keeps the output power mode of each of a set of DAC channels (eight by default) and drives the enable and termination-select lines of that channel. An upstream serial front end decodes each command word into a 4-bit operation code and a 12-bit payload, then presents both for one clock cycle together with a strobe. The block reacts to two operation codes. The power command changes the mode of the channels chosen by a bitmask, and every channel whose mask bit is zero keeps its mode. The reset command sends every channel to its safe default.

Each channel is in one of four modes: active (buffer driving), high impedance, shutdown with a 1k pull to ground, or shutdown with a 100k pull to ground. The 100k shutdown is the default after reset, after the reset command and while the active-low clear is held. A global flag reports when no channel is active, so the shared bias can be gated off. All outputs are registered.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every channel state is 00 (100k shutdown), `ch_term_100k` is all ones, `ch_drive_en` and `ch_term_1k` are all zeros, and `all_off` is 1.
- R2: A strobe with operation code 1111 and payload bits 11:10 equal to 11 puts every masked channel in the active mode (state 11) on the clock edge that samples the strobe.
- R3: Sub-code 01 in payload bits 11:10 of a 1111 command puts every masked channel in high-impedance shutdown (state 01).
- R4: Sub-code 10 of a 1111 command puts every masked channel in 1k shutdown (state 10).
- R5: Sub-code 00 of a 1111 command puts every masked channel in 100k shutdown (state 00).
- R6: The channel mask is payload bits 9 down to 2: bit 2 selects channel 1 (state bits 1:0), bit 9 selects channel 8 (state bits 15:14). Payload bits 1:0 have no effect.
- R7: A channel whose mask bit is 0 keeps its present mode through a power command.
- R8: A strobe with operation code 0001 puts every channel in 100k shutdown, whatever the payload holds.
- R9: `clr_n` low puts every channel in 100k shutdown on the next edge. It wins over a power command given in the same cycle.
- R10: With the strobe low, or with any operation code other than 1111 and 0001, no channel state changes.
- R11: `all_off` is 1 exactly when no channel is in the active mode. It updates on the same edge as the channel states.
- R12: For each channel, `ch_drive_en` is 1 only in state 11, `ch_term_1k` only in state 10 and `ch_term_100k` only in state 00. In state 01 all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Clear, active low, sampled on the clock |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_code | input | 4 | Operation code of the command |
| cmd_payload | input | N_CH+4 | Sub-code (top two bits), channel mask, two unused bits |
| ch_state | output | 2*N_CH | Mode of each channel, two bits per channel, channel 1 lowest |
| ch_drive_en | output | N_CH | Output buffer enable per channel |
| ch_term_1k | output | N_CH | 1k pull-to-ground select per channel |
| ch_term_100k | output | N_CH | 100k pull-to-ground select per channel |
| all_off | output | 1 | High when no channel is active |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. The edge that samples a strobe, a clear or a reset also loads the channel states, the three per-channel select vectors and `all_off`, because the block has no deeper pipeline. The bench drives inputs on the falling edge and holds them across one rising edge. It reads the outputs at the next falling edge, half a period after the register update, and compares them with a per-channel model kept in the bench. Commands that must leave the states alone are checked in the same way, one edge after they are applied.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  // Per-channel output mode. The 2-bit encoding equals the power
  // sub-code that selects the mode.
  typedef enum logic [1:0] {
    MODE_PD100K = 2'b00,
    MODE_HIZ    = 2'b01,
    MODE_PD1K   = 2'b10,
    MODE_ACTIVE = 2'b11
  } mode_t;

  localparam logic [3:0] OP_RESET = 4'b0001;
  localparam logic [3:0] OP_POWER = 4'b1111;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_mode_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int PAY_W = N_CH + 4
) (
  input  logic             clr_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [PAY_W-1:0] cmd_payload,
  output logic             clear_all,
  output logic [N_CH-1:0]  load_mask,
  output mode_t            new_mode
);

  logic is_power;
  logic is_reset;
  logic unused_pad_bits;

  assign is_reset  = cmd_valid && (cmd_code == OP_RESET);
  assign is_power  = cmd_valid && (cmd_code == OP_POWER);

  // Clear and the reset command outrank any mode update.
  assign clear_all = !clr_n || is_reset;
  assign load_mask = (is_power && !clear_all) ? cmd_payload[N_CH+1:2] : '0;
  assign new_mode  = mode_t'(cmd_payload[PAY_W-1 -: 2]);

  // The two lowest payload bits carry no meaning.
  assign unused_pad_bits = ^cmd_payload[1:0];

endmodule

// File: rtl/pwr_chan_cell.sv
module pwr_chan_cell
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clear_all,
  input  logic       load,
  input  mode_t      new_mode,
  output logic [1:0] state,
  output logic       drive_en,
  output logic       term_1k,
  output logic       term_100k,
  output logic       nxt_active
);

  mode_t cur;
  mode_t nxt;

  always_comb begin
    if (clear_all)  nxt = MODE_PD100K;
    else if (load)  nxt = new_mode;
    else            nxt = cur;
  end

  assign nxt_active = (nxt == MODE_ACTIVE);

  // Selects are registered from the next mode, so they move on the
  // same edge as the mode itself.
  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= MODE_PD100K;
      drive_en  <= 1'b0;
      term_1k   <= 1'b0;
      term_100k <= 1'b1;
    end else begin
      cur       <= nxt;
      drive_en  <= (nxt == MODE_ACTIVE);
      term_1k   <= (nxt == MODE_PD1K);
      term_100k <= (nxt == MODE_PD100K);
    end
  end

  assign state = cur;

endmodule

// File: rtl/pwr_alloff_flag.sv
module pwr_alloff_flag #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] nxt_active,
  output logic            all_off
);

  always_ff @(posedge clk) begin
    if (rst) all_off <= 1'b1;
    else     all_off <= ~|nxt_active;
  end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int PAY_W = N_CH + 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_n,
  input  logic               cmd_valid,
  input  logic [3:0]         cmd_code,
  input  logic [PAY_W-1:0]   cmd_payload,
  output logic [2*N_CH-1:0]  ch_state,
  output logic [N_CH-1:0]    ch_drive_en,
  output logic [N_CH-1:0]    ch_term_1k,
  output logic [N_CH-1:0]    ch_term_100k,
  output logic               all_off
);

  logic            clear_all;
  logic [N_CH-1:0] load_mask;
  mode_t           new_mode;
  logic [N_CH-1:0] nxt_active;

  pwr_cmd_decode #(.N_CH(N_CH)) u_dec (
    .clr_n       (clr_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_payload (cmd_payload),
    .clear_all   (clear_all),
    .load_mask   (load_mask),
    .new_mode    (new_mode)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    pwr_chan_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .clear_all  (clear_all),
      .load       (load_mask[i]),
      .new_mode   (new_mode),
      .state      (ch_state[2*i +: 2]),
      .drive_en   (ch_drive_en[i]),
      .term_1k    (ch_term_1k[i]),
      .term_100k  (ch_term_100k[i]),
      .nxt_active (nxt_active[i])
    );
  end

  pwr_alloff_flag #(.N_CH(N_CH)) u_off (
    .clk        (clk),
    .rst        (rst),
    .nxt_active (nxt_active),
    .all_off    (all_off)
  );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int N_CH = 8,
  localparam int PAY_W = N_CH + 4
) (
  input logic               clk,
  input logic               rst,
  input logic               clr_n,
  input logic               cmd_valid,
  input logic [3:0]         cmd_code,
  input logic [PAY_W-1:0]   cmd_payload,
  input logic [2*N_CH-1:0]  ch_state,
  input logic [N_CH-1:0]    ch_drive_en,
  input logic [N_CH-1:0]    ch_term_1k,
  input logic [N_CH-1:0]    ch_term_100k,
  input logic               all_off
);

  logic pwr_cmd;
  assign pwr_cmd = clr_n && cmd_valid && (cmd_code == 4'b1111);

  // R9: clear forces every channel to 100k shutdown
  a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (ch_state == '0));

  // R8: reset command forces every channel to 100k shutdown
  a_r8_reset_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 4'b0001) |=> (ch_state == '0));

  // R10: no strobe, no change
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !cmd_valid) |=> $stable(ch_state));

  // R11: all_off tracks absence of active channels
  a_r11_alloff: assert property (@(posedge clk) disable iff (rst)
    all_off == (ch_drive_en == '0));

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    // R12: at most one select per channel
    a_r12_one_select: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ch_drive_en[i], ch_term_1k[i], ch_term_100k[i]}));

    // R2: masked channel takes the sub-code as its mode
    a_r2_masked_load: assert property (@(posedge clk) disable iff (rst)
      (pwr_cmd && cmd_payload[i+2]) |=>
        (ch_state[2*i +: 2] == $past(cmd_payload[PAY_W-1 -: 2])));

    // R7: unmasked channel keeps its mode
    a_r7_unmasked_keep: assert property (@(posedge clk) disable iff (rst)
      (pwr_cmd && !cmd_payload[i+2]) |=> $stable(ch_state[2*i +: 2]));
  end

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int PW = N + 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            clr_n = 1'b1;
  logic            cmd_valid = 1'b0;
  logic [3:0]      cmd_code = '0;
  logic [PW-1:0]   cmd_payload = '0;
  logic [2*N-1:0]  ch_state;
  logic [N-1:0]    ch_drive_en, ch_term_1k, ch_term_100k;
  logic            all_off;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_m [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.N_CH(N)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_payload(cmd_payload), .ch_state(ch_state),
    .ch_drive_en(ch_drive_en), .ch_term_1k(ch_term_1k),
    .ch_term_100k(ch_term_100k), .all_off(all_off)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare every output with the model.
  task automatic check_all(input string req);
    logic [2*N-1:0] s;
    logic [N-1:0] d, k1, k100;
    logic any;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      s[2*i +: 2] = exp_m[i];
      d[i]    = (exp_m[i] == 2'b11);
      k1[i]   = (exp_m[i] == 2'b10);
      k100[i] = (exp_m[i] == 2'b00);
      any = any | d[i];
    end
    check({req, " state"}, 32'(ch_state), 32'(s));
    check("R12 drive_en", 32'(ch_drive_en), 32'(d));
    check("R12 term_1k", 32'(ch_term_1k), 32'(k1));
    check("R12 term_100k", 32'(ch_term_100k), 32'(k100));
    check("R11 all_off", 32'(all_off), 32'(!any));
  endtask

  // Apply one command for one edge; sample at the next falling edge.
  task automatic apply(input logic [3:0] code, input logic [PW-1:0] pay, input logic v);
    @(negedge clk);
    cmd_valid = v; cmd_code = code; cmd_payload = pay;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; cmd_payload = '0;
  endtask

  function automatic logic [PW-1:0] pwr_pay(input logic [1:0] sub, input logic [N-1:0] mask, input logic [1:0] pad);
    return {sub, mask, pad};
  endfunction

  task automatic model_pwr(input logic [1:0] sub, input logic [N-1:0] mask);
    for (int i = 0; i < N; i++) if (mask[i]) exp_m[i] = sub;
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) exp_m[i] = 2'b00;
  endtask

  task automatic t_reset();
    model_clear();
    check_all("R1");
    check("R1 term_100k all", 32'(ch_term_100k), 32'({N{1'b1}}));
  endtask

  task automatic t_power_up();  // R2, R6: channels 1 and 3
    apply(4'b1111, pwr_pay(2'b11, 8'h05, 2'b00), 1'b1);
    model_pwr(2'b11, 8'h05);
    check_all("R2");
    check("R6 ch1 bits", 32'(ch_state[1:0]), 32'h3);
  endtask

  task automatic t_hiz();  // R3, R6: channel 8 via payload bit 9
    apply(4'b1111, pwr_pay(2'b01, 8'h80, 2'b00), 1'b1);
    model_pwr(2'b01, 8'h80);
    check_all("R3");
    check("R6 ch8 bits", 32'(ch_state[15:14]), 32'h1);
  endtask

  task automatic t_1k();  // R4
    apply(4'b1111, pwr_pay(2'b10, 8'h30, 2'b00), 1'b1);
    model_pwr(2'b10, 8'h30);
    check_all("R4");
  endtask

  task automatic t_100k();  // R5, R7
    apply(4'b1111, pwr_pay(2'b00, 8'h01, 2'b00), 1'b1);
    model_pwr(2'b00, 8'h01);
    check_all("R5");
    check("R7 ch3 kept", 32'(ch_state[5:4]), 32'h3);
  endtask

  task automatic t_pad_bits();  // R6, R7: only pad bits set
    apply(4'b1111, pwr_pay(2'b11, 8'h00, 2'b11), 1'b1);
    check_all("R6");
    apply(4'b1111, pwr_pay(2'b10, 8'h00, 2'b01), 1'b1);
    check_all("R7");
  endtask

  task automatic t_other_codes();  // R10
    apply(4'b0010, pwr_pay(2'b11, 8'hFF, 2'b00), 1'b1);
    check_all("R10 code 0010");
    apply(4'b1110, pwr_pay(2'b00, 8'hFF, 2'b00), 1'b1);
    check_all("R10 code 1110");
    apply(4'b0000, pwr_pay(2'b00, 8'hFF, 2'b00), 1'b1);
    check_all("R10 code 0000");
    apply(4'b1111, pwr_pay(2'b00, 8'hFF, 2'b00), 1'b0);
    check_all("R10 no strobe");
  endtask

  task automatic t_reset_cmd();  // R8
    apply(4'b1111, pwr_pay(2'b11, 8'hFF, 2'b00), 1'b1);
    model_pwr(2'b11, 8'hFF);
    check_all("R2 all");
    apply(4'b0001, pwr_pay(2'b11, 8'hFF, 2'b11), 1'b1);
    model_clear();
    check_all("R8");
  endtask

  task automatic t_clear();  // R9
    apply(4'b1111, pwr_pay(2'b10, 8'hAA, 2'b00), 1'b1);
    model_pwr(2'b10, 8'hAA);
    check_all("R4 alt");
    @(negedge clk);
    clr_n = 1'b0; cmd_valid = 1'b1; cmd_code = 4'b1111;
    cmd_payload = pwr_pay(2'b11, 8'hFF, 2'b00);
    @(negedge clk);
    clr_n = 1'b1; cmd_valid = 1'b0; cmd_code = '0; cmd_payload = '0;
    model_clear();
    check_all("R9");
  endtask

  task automatic t_alloff();  // R11
    apply(4'b1111, pwr_pay(2'b11, 8'h40, 2'b00), 1'b1);
    model_pwr(2'b11, 8'h40);
    check_all("R11 one active");
    check("R11 flag low", 32'(all_off), 32'h0);
    apply(4'b1111, pwr_pay(2'b01, 8'h40, 2'b00), 1'b1);
    model_pwr(2'b01, 8'h40);
    check_all("R11 none active");
    check("R11 flag high", 32'(all_off), 32'h1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) exp_m[i] = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();  // checked while rst still high
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_power_up();
    t_hiz();
    t_1k();
    t_100k();
    t_pad_bits();
    t_other_codes();
    t_reset_cmd();
    t_clear();
    t_alloff();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule